// File: doc/BRIEF.md
# Tear-Free Split Counter Reader

This block lets a bus master that may only issue 16-bit accesses read a 32-bit counter as two halves and still get one coherent value. The counter runs on its own functional clock, which has no phase or frequency relation to the bus clock. The block carries the counter across as a Gray-coded word through a chain of synchronizer flops. It converts the word back to binary on the bus side, so each read sees a value that the counter really held and never one caught between two increments.

A 16-bit read of the lower half returns the low 16 bits of that synchronized value. The same read copies the whole value into a 32-bit shadow register. A following 16-bit read of the upper half is answered from the shadow, so the two halves belong to the same sample even if the counter has moved on. A full-width read returns the synchronized value directly and leaves the shadow alone. Every other offset reads as zero. Read data is registered and holds between reads.

The Gray crossing assumes that, once out of reset, the counter input changes by at most one count per counter clock. Each clock domain has its own active-low reset, which is asserted asynchronously and released synchronously inside the block.

Top module: `srs_split_reader`

## Requirements
- R1: After bus reset, `rd_data` and the shadow are zero, so an upper-half read made before any lower-half read returns zero.
- R2: A read with `rd_wide`=0 at offset 0x08 puts bits 15:0 of the synchronized counter on `rd_data[15:0]`, with bits 31:16 zero. It also loads the whole synchronized value into the shadow.
- R3: A read with `rd_wide`=0 at offset 0x0A puts bits 31:16 of the shadow on `rd_data[15:0]`, with bits 31:16 zero. It never takes data from the live counter.
- R4: A read with `rd_wide`=1 at offset 0x08 returns all 32 bits of the synchronized counter on `rd_data` and does not change the shadow.
- R5: A read at any other offset, or a read with `rd_wide`=1 at 0x0A, returns zero and does not change the shadow.
- R6: `rd_data` is updated at the bus clock edge that samples `rd_en`=1 and keeps its value on every edge where `rd_en`=0.
- R7: The counter crosses as a Gray-coded copy through `SYNC_STAGES` bus-clock flops. A counter value that has been stable for one counter clock plus `SYNC_STAGES`+1 bus clocks is the value that reads return. While the counter advances by one per counter clock, including across a carry from bit 15 into bit 16, a lower-then-upper read pair yields a value the counter actually held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk | input | 1 | Counter (functional) clock |
| cnt_rst_n | input | 1 | Active-low reset for the counter-side logic, asynchronous assert |
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low reset for the bus-side logic, asynchronous assert |
| cnt_value | input | 32 | Live counter value in the counter clock domain |
| rd_en | input | 1 | Read strobe, one bus cycle per access |
| rd_wide | input | 1 | Access size: 1 = 32-bit, 0 = 16-bit |
| rd_addr | input | 8 | Byte offset of the access |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the block with its defaults: a 32-bit counter, 8-bit offsets with the halves at 0x08 and 0x0A, and two synchronizer stages. With two stages, a new counter value reaches the read path within a few bus cycles, so the table can change the counter between reads and show the upper half still answered from the older shadow. The counter clock period is chosen so that its edges never coincide with the bench's sampling points. The bench then runs the counter freely across the 0xFFFF to 0x10000 carry and checks that a split read never returns a torn value. It also checks that a bus reset partway through the run clears the shadow again.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_LO   = 2'd1,
    RK_HI   = 2'd2,
    RK_WIDE = 2'd3
  } rd_kind_e;

endpackage

// File: rtl/srs_rst_sync.sv
module srs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];

endmodule

// File: rtl/srs_gray_tx.sv
module srs_gray_tx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bin_in,
  output logic [W-1:0] gray_out
);

  logic [W-1:0] gray_d;
  logic [W-1:0] gray_q;

  always_comb begin
    gray_d = bin_in ^ (bin_in >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= gray_d;
  end

  assign gray_out = gray_q;

endmodule

// File: rtl/srs_gray_rx.sv
module srs_gray_rx #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = gray_in;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  always_comb begin
    bin_out[W-1] = stage_q[STAGES-1][W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
    end
  end

endmodule

// File: rtl/srs_shadow_port.sv
module srs_shadow_port
  import srs_pkg::*;
#(
  parameter int                W      = 32,
  parameter int                AW     = 8,
  parameter logic [AW-1:0]     LO_OFS = 8'h08,
  parameter logic [AW-1:0]     HI_OFS = 8'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  live,
  input  logic          rd_en,
  input  logic          rd_wide,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  shadow,
  output logic [W-1:0]  rd_data
);

  localparam int HW = W / 2;

  rd_kind_e     kind;
  logic [W-1:0] shadow_d, shadow_q;
  logic [W-1:0] data_d, data_q;
  logic         shadow_en;

  always_comb begin
    if (rd_wide) kind = (rd_addr == LO_OFS) ? RK_WIDE : RK_NONE;
    else if (rd_addr == LO_OFS) kind = RK_LO;
    else if (rd_addr == HI_OFS) kind = RK_HI;
    else kind = RK_NONE;
  end

  always_comb begin
    shadow_en = rd_en && (kind == RK_LO);
    shadow_d  = live;
    unique case (kind)
      RK_LO:   data_d = {{(W-HW){1'b0}}, live[HW-1:0]};
      RK_HI:   data_d = {{(W-HW){1'b0}}, shadow_q[W-1:HW]};
      RK_WIDE: data_d = live;
      default: data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (rd_en) data_q <= data_d;
  end

  assign shadow  = shadow_q;
  assign rd_data = data_q;

endmodule

// File: rtl/srs_split_reader.sv
module srs_split_reader #(
  parameter int            CNT_W       = 32,
  parameter int            ADDR_W      = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LO_OFS  = 8'h08,
  parameter logic [ADDR_W-1:0] HI_OFS  = 8'h0A
) (
  input  logic              cnt_clk,
  input  logic              cnt_rst_n,
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              rd_en,
  input  logic              rd_wide,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);

  logic             cnt_rst_s;
  logic             bus_rst_s;
  logic [CNT_W-1:0] gray_w;
  logic [CNT_W-1:0] sync_bin_w;
  logic [CNT_W-1:0] shadow_w;

  srs_rst_sync #(.STAGES(2)) u_cnt_rst (
    .clk(cnt_clk), .arst_n(cnt_rst_n), .rst_n_s(cnt_rst_s)
  );

  srs_rst_sync #(.STAGES(2)) u_bus_rst (
    .clk(bus_clk), .arst_n(bus_rst_n), .rst_n_s(bus_rst_s)
  );

  srs_gray_tx #(.W(CNT_W)) u_tx (
    .clk(cnt_clk), .rst_n(cnt_rst_s), .bin_in(cnt_value), .gray_out(gray_w)
  );

  srs_gray_rx #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_rx (
    .clk(bus_clk), .rst_n(bus_rst_s), .gray_in(gray_w), .bin_out(sync_bin_w)
  );

  srs_shadow_port #(
    .W(CNT_W), .AW(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
  ) u_port (
    .clk(bus_clk), .rst_n(bus_rst_s), .live(sync_bin_w),
    .rd_en(rd_en), .rd_wide(rd_wide), .rd_addr(rd_addr),
    .shadow(shadow_w), .rd_data(rd_data)
  );

endmodule

// File: rtl/srs_split_reader_chk.sv
module srs_split_reader_chk #(
  parameter int            CNT_W  = 32,
  parameter int            ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] HI_OFS = 8'h0A
) (
  input logic              clk,
  input logic              rst_s,
  input logic              rd_en,
  input logic              rd_wide,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CNT_W-1:0]  sync_bin,
  input logic [CNT_W-1:0]  shadow,
  input logic [CNT_W-1:0]  rd_data
);

  localparam int HW = CNT_W / 2;

  logic lo_rd, hi_rd, wide_rd;
  assign lo_rd   = rd_en && !rd_wide && (rd_addr == LO_OFS);
  assign hi_rd   = rd_en && !rd_wide && (rd_addr == HI_OFS);
  assign wide_rd = rd_en &&  rd_wide && (rd_addr == LO_OFS);

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> (rd_data == '0) && (shadow == '0));

  assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_s)
    lo_rd |=> (shadow == $past(sync_bin)) &&
              (rd_data == {{(CNT_W-HW){1'b0}}, $past(sync_bin[HW-1:0])}));

  assert_hi_from_shadow_R3: assert property (@(posedge clk) disable iff (!rst_s)
    hi_rd |=> rd_data == {{(CNT_W-HW){1'b0}}, $past(shadow[CNT_W-1:HW])});

  assert_wide_direct_R4: assert property (@(posedge clk) disable iff (!rst_s)
    wide_rd |=> rd_data == $past(sync_bin));

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !lo_rd |=> $stable(shadow));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_en |=> $stable(rd_data));

endmodule

bind srs_split_reader srs_split_reader_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
) chk_i (
  .clk(bus_clk), .rst_s(bus_rst_s), .rd_en(rd_en), .rd_wide(rd_wide),
  .rd_addr(rd_addr), .sync_bin(sync_bin_w), .shadow(shadow_w),
  .rd_data(rd_data)
);

// File: tb/srs_split_reader_tb_top.sv
`timescale 1ns/100ps
module srs_split_reader_tb_top;

  logic        cnt_clk = 1'b0;
  logic        bus_clk = 1'b0;
  logic        cnt_rst_n = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic [31:0] cnt_base = 32'h0;
  logic [31:0] cnt_step = 32'h0;
  logic [31:0] cnt_value;
  logic        run = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_wide = 1'b0;
  logic [7:0]  rd_addr = 8'h0;
  logic [31:0] rd_data;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5   bus_clk = ~bus_clk;
  always #7.3 cnt_clk = ~cnt_clk;

  always @(posedge cnt_clk) begin
    if (run) cnt_step <= cnt_step + 32'd1;
    else     cnt_step <= 32'd0;
  end
  assign cnt_value = cnt_base + cnt_step;

  srs_split_reader dut_i (
    .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n), .bus_clk(bus_clk),
    .bus_rst_n(bus_rst_n), .cnt_value(cnt_value), .rd_en(rd_en),
    .rd_wide(rd_wide), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {wide, addr, counter, expected}
  localparam int NV = 12;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h08, 32'h12345678, 32'h12345678},  // R4
    {1'b0, 8'h08, 32'h12345678, 32'h00005678},  // R2
    {1'b0, 8'h0A, 32'hABCD0001, 32'h00001234},  // R3 shadow, not live
    {1'b1, 8'h08, 32'hABCD0001, 32'hABCD0001},  // R4
    {1'b0, 8'h0A, 32'hABCD0001, 32'h00001234},  // R4 shadow untouched
    {1'b0, 8'h08, 32'hABCD0001, 32'h00000001},  // R2
    {1'b0, 8'h0A, 32'hABCD0001, 32'h0000ABCD},  // R3
    {1'b0, 8'h04, 32'h55AA55AA, 32'h00000000},  // R5
    {1'b0, 8'h0A, 32'h55AA55AA, 32'h0000ABCD},  // R5 shadow untouched
    {1'b1, 8'h0A, 32'h55AA55AA, 32'h00000000},  // R5 wide at upper
    {1'b0, 8'h08, 32'hFFFF0000, 32'h00000000},  // R2
    {1'b0, 8'h0A, 32'hFFFF0000, 32'h0000FFFF}   // R3
  };

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic wide, input logic [7:0] addr);
    @(negedge bus_clk);
    rd_en = 1'b1; rd_wide = wide; rd_addr = addr;
    @(negedge bus_clk);
    rd_en = 1'b0; rd_wide = 1'b0; rd_addr = 8'h0;
  endtask

  task automatic settle();
    repeat (8) @(negedge bus_clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    logic [31:0] held, lo_part, hi_part, joined, cnt_at_lo;
    cnt_base = 32'h0;
    repeat (4) @(negedge bus_clk);
    cnt_rst_n = 1'b1;
    bus_rst_n = 1'b1;
    settle();
    check("R1 reset rd_data", rd_data, 32'h0);
    do_read(1'b0, 8'h0A);
    check("R1 upper before lower", rd_data, 32'h0);

    for (int v = 0; v < NV; v++) begin
      cnt_base = VEC[v][63:32];
      settle();
      do_read(VEC[v][72], VEC[v][71:64]);
      check($sformatf("R2-5 vector %0d", v), rd_data, VEC[v][31:0]);
    end

    // R6: data holds with no read
    held = rd_data;
    cnt_base = 32'h0BADF00D;
    settle();
    check("R6 hold between reads", rd_data, held);

    // R7: latency of a stable value
    cnt_base = 32'h00C0FFEE;
    settle();
    do_read(1'b1, 8'h08);
    check("R7 settled wide value", rd_data, 32'h00C0FFEE);

    // R7: split read across carry into upper half
    cnt_base = 32'h0000FFF0;
    settle();
    run = 1'b1;
    @(negedge bus_clk);
    while (cnt_value < 32'h0000FFFD) @(negedge bus_clk);
    cnt_at_lo = cnt_value;
    do_read(1'b0, 8'h08);
    lo_part = rd_data;
    repeat (6) @(negedge bus_clk);
    do_read(1'b0, 8'h0A);
    hi_part = rd_data;
    joined = {hi_part[15:0], lo_part[15:0]};
    check("R7 no tear lower bound", 32'(joined >= 32'h0000FFF0), 32'd1);
    check("R7 no tear upper bound", 32'(joined <= cnt_at_lo), 32'd1);
    check("R7 counter passed carry", 32'(cnt_value > 32'h00010000), 32'd1);
    run = 1'b0;
    settle();

    // R1: bus reset partway clears shadow
    cnt_base = 32'h7777AAAA;
    settle();
    do_read(1'b0, 8'h08);
    check("R2 lower before reset", rd_data, 32'h0000AAAA);
    @(negedge bus_clk);
    bus_rst_n = 1'b0;
    repeat (2) @(negedge bus_clk);
    check("R1 rd_data in reset", rd_data, 32'h0);
    bus_rst_n = 1'b1;
    settle();
    do_read(1'b0, 8'h0A);
    check("R1 shadow cleared by reset", rd_data, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule